// File: doc/BRIEF.md
# Instruction Exception Arbiter

This block sits between an instruction decoder and the exception sequencer of a processor core. On every cycle it looks at the class the decoder gives the current instruction, the address of that instruction, and the status register. From these it decides whether the instruction must be stopped before it runs. An instruction is stopped when it is illegal, when it is an unimplemented opcode to be emulated in software, or when it is a supervisor-only operation issued in user mode. The block also watches the completion strobe from the execute stage. When tracing is enabled, it raises a trace exception after an instruction finishes.

When an exception is raised, the block asserts a kill signal in the same cycle so that the instruction does not execute. From the next cycle it presents an exception request with a vector number, the program counter to stack and a copy of the status register. All of these hold until the sequencer acknowledges them. While a request is pending, new decode and completion inputs are ignored.

Top module: `insn_exc_arb`

## Requirements
- R1: A decode with `dec_class` = 1 (illegal) raises a request with vector 4 in either privilege mode. The stacked PC is `dec_pc` and the stacked SR is `sr_in`.
- R2: `dec_class` = 2 (unimplemented, A-line group) raises vector 10. `dec_class` = 3 (unimplemented, F-line group) raises vector 11. Neither uses vector 4.
- R3: `dec_class` values 4 through 15 are the twelve supervisor-only operations: logical immediate ops to SR (three), SR moves in both directions, user stack pointer move, control register move, alternate space move, reset, return from exception, stop and low-power stop. When `sr_in[13]` = 0 (user mode), each raises vector 8. When `sr_in[13]` = 1, none of them raises anything.
- R4: `exec_kill` is high in the same cycle as a decode that raises an exception, and low for a decode that raises none.
- R5: For a decode exception, `exc_pc` equals the address of the offending instruction and `exc_sr` equals the status register presented with it.
- R6: When {`sr_in[15]`,`sr_in[14]`} = 10, every `cmp_valid` pulse raises vector 9, with `exc_pc` = `cmp_pc`.
- R7: When {`sr_in[15]`,`sr_in[14]`} = 01, a completion raises vector 9 only if `cmp_flow` = 1.
- R8: When {`sr_in[15]`,`sr_in[14]`} is 00 or 11, completions raise no exception.
- R9: If a decode fault and a trace condition occur in the same cycle, the decode fault wins.
- R10: `exc_req` is high from the cycle after the triggering edge. It and `exc_vec`, `exc_pc` and `exc_sr` hold until `exc_ack`. Inputs seen while the request is pending are ignored, and `exec_kill` stays low. The request drops the cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decoded instruction presented |
| dec_class | input | 4 | Instruction class code (see R1–R3) |
| dec_pc | input | PCW | Address of the first word of the decoded instruction |
| sr_in | input | SRW | Current status register |
| cmp_valid | input | 1 | Instruction completed this cycle |
| cmp_flow | input | 1 | Completed instruction changed program flow |
| cmp_pc | input | PCW | Address of the next instruction after completion |
| exc_ack | input | 1 | Sequencer accepts the pending request |
| exec_kill | output | 1 | Suppress execution of the current decode |
| exc_req | output | 1 | Exception request pending |
| exc_vec | output | VECW | Vector number |
| exc_pc | output | PCW | Program counter to stack |
| exc_sr | output | SRW | Status register copy to stack |

## Verification
`exec_kill` is combinational, so the bench reads it shortly after it drives a decode and before the next rising edge. The request and its vector, PC and SR pass through one register. The bench therefore checks them at the falling edge after the edge that captured the stimulus. Inputs are withdrawn at that same point, so the hold checks for R10 see only registered state. After an acknowledge has been sampled on one edge, the bench expects `exc_req` low at the next falling edge.

// File: rtl/insn_exc_arb.sv
module insn_exc_arb #(
  parameter int PCW     = 32,
  parameter int SRW     = 16,
  parameter int VECW    = 8,
  parameter int S_BIT   = 13,
  parameter int T1_BIT  = 15,
  parameter int T0_BIT  = 14,
  parameter int V_ILL   = 4,
  parameter int V_PRIV  = 8,
  parameter int V_TRACE = 9,
  parameter int V_LINEA = 10,
  parameter int V_LINEF = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dec_valid,
  input  logic [3:0]      dec_class,
  input  logic [PCW-1:0]  dec_pc,
  input  logic [SRW-1:0]  sr_in,
  input  logic            cmp_valid,
  input  logic            cmp_flow,
  input  logic [PCW-1:0]  cmp_pc,
  input  logic            exc_ack,
  output logic            exec_kill,
  output logic            exc_req,
  output logic [VECW-1:0] exc_vec,
  output logic [PCW-1:0]  exc_pc,
  output logic [SRW-1:0]  exc_sr
);
  localparam logic [3:0] C_ILL   = 4'd1;
  localparam logic [3:0] C_LINEA = 4'd2;
  localparam logic [3:0] C_LINEF = 4'd3;
  localparam logic [3:0] C_PRIV0 = 4'd4;

  logic [1:0]      tmode;
  logic            priv_fault, dec_fault, trace_hit;
  logic [VECW-1:0] dec_vec;

  assign tmode      = {sr_in[T1_BIT], sr_in[T0_BIT]};
  assign priv_fault = (dec_class >= C_PRIV0) && !sr_in[S_BIT];
  assign dec_fault  = dec_valid && (dec_class == C_ILL || dec_class == C_LINEA ||
                                    dec_class == C_LINEF || priv_fault);
  assign trace_hit  = cmp_valid && (tmode == 2'b10 || (tmode == 2'b01 && cmp_flow));
  assign exec_kill  = !exc_req && dec_fault;

  always_comb begin
    unique case (dec_class)
      C_ILL:   dec_vec = VECW'(V_ILL);
      C_LINEA: dec_vec = VECW'(V_LINEA);
      C_LINEF: dec_vec = VECW'(V_LINEF);
      default: dec_vec = VECW'(V_PRIV);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_req <= 1'b0;
      exc_vec <= '0;
      exc_pc  <= '0;
      exc_sr  <= '0;
    end else if (exc_req) begin
      if (exc_ack) exc_req <= 1'b0;
    end else if (dec_fault) begin
      exc_req <= 1'b1;
      exc_vec <= dec_vec;
      exc_pc  <= dec_pc;
      exc_sr  <= sr_in;
    end else if (trace_hit) begin
      exc_req <= 1'b1;
      exc_vec <= VECW'(V_TRACE);
      exc_pc  <= cmp_pc;
      exc_sr  <= sr_in;
    end
  end
endmodule

// File: rtl/insn_exc_arb_chk.sv
module insn_exc_arb_chk #(
  parameter int PCW  = 32,
  parameter int SRW  = 16,
  parameter int VECW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dec_valid,
  input logic [3:0]      dec_class,
  input logic [SRW-1:0]  sr_in,
  input logic            cmp_valid,
  input logic            exc_ack,
  input logic            exec_kill,
  input logic            exc_req,
  input logic [VECW-1:0] exc_vec,
  input logic [PCW-1:0]  exc_pc,
  input logic [SRW-1:0]  exc_sr
);
  p_illegal_vec_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req && dec_valid && dec_class == 4'd1) |=> (exc_req && exc_vec == VECW'(4)));

  p_priv_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req && dec_valid && dec_class >= 4'd4 && !sr_in[13]) |=> (exc_req && exc_vec == VECW'(8)));

  p_kill_leads_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exec_kill |=> exc_req);

  p_no_trace_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req && !dec_valid && cmp_valid && sr_in[15] == sr_in[14]) |=> !exc_req);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !exc_ack) |=> (exc_req && $stable(exc_vec) && $stable(exc_pc) && $stable(exc_sr)));

  p_ack_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && exc_ack) |=> !exc_req);

  p_no_kill_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> !exec_kill);
endmodule

bind insn_exc_arb insn_exc_arb_chk #(.PCW(PCW), .SRW(SRW), .VECW(VECW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_class(dec_class),
  .sr_in(sr_in), .cmp_valid(cmp_valid), .exc_ack(exc_ack), .exec_kill(exec_kill),
  .exc_req(exc_req), .exc_vec(exc_vec), .exc_pc(exc_pc), .exc_sr(exc_sr)
);

// File: tb/sim_insn_exc_arb.sv
`timescale 1ns/1ps
module sim_insn_exc_arb;
  logic        clk = 0, rst_n = 0;
  logic        dec_valid = 0, cmp_valid = 0, cmp_flow = 0, exc_ack = 0;
  logic [3:0]  dec_class = 0;
  logic [31:0] dec_pc = 0, cmp_pc = 0;
  logic [15:0] sr_in = 0;
  logic        exec_kill, exc_req;
  logic [7:0]  exc_vec;
  logic [31:0] exc_pc;
  logic [15:0] exc_sr;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  insn_exc_arb u0 (.clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_class(dec_class),
    .dec_pc(dec_pc), .sr_in(sr_in), .cmp_valid(cmp_valid), .cmp_flow(cmp_flow),
    .cmp_pc(cmp_pc), .exc_ack(exc_ack), .exec_kill(exec_kill), .exc_req(exc_req),
    .exc_vec(exc_vec), .exc_pc(exc_pc), .exc_sr(exc_sr));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    dec_valid = 0; cmp_valid = 0; cmp_flow = 0; exc_ack = 0;
  endtask

  task automatic ack();
    exc_ack = 1;
    @(negedge clk);
    exc_ack = 0;
    chk(!exc_req, "R10 drop", exc_req, 0);
  endtask

  // present one decode; returns kill seen in the same cycle
  task automatic decode(input logic [3:0] cls, input logic [31:0] pc, input logic [15:0] sr,
                        output bit kill);
    @(negedge clk);
    dec_valid = 1; dec_class = cls; dec_pc = pc; sr_in = sr;
    #0.5 kill = exec_kill;
    @(negedge clk);
    idle();
  endtask

  task automatic t_decode_fault(input logic [3:0] cls, input logic [7:0] vec, input string req);
    bit k;
    decode(cls, 32'h1000 + cls, 16'h0000, k);
    chk(k, "R4 kill", k, 1);
    chk(exc_req && exc_vec == vec, req, exc_vec, vec);
    chk(exc_pc == 32'h1000 + cls && exc_sr == 16'h0000, "R5 pc/sr", exc_pc, 32'h1000 + cls);
    ack();
  endtask

  task automatic t_illegal_super();
    bit k;
    decode(4'd1, 32'h2468, 16'h2000, k);
    chk(exc_req && exc_vec == 8'd4, "R1 supervisor illegal", exc_vec, 4);
    chk(exc_sr == 16'h2000 && exc_pc == 32'h2468, "R1 saved sr/pc", exc_sr, 16'h2000);
    ack();
  endtask

  task automatic t_priv_super();
    for (int c = 4; c < 16; c++) begin
      bit k;
      decode(4'(c), 32'h3000, 16'h2000, k);
      chk(!k, "R4 no kill supervisor", k, 0);
      chk(!exc_req, "R3 supervisor allowed", exc_req, 0);
    end
  endtask

  task automatic t_ordinary();
    bit k;
    decode(4'd0, 32'h40, 16'h0000, k);
    chk(!k && !exc_req, "R4 ordinary", {k, exc_req}, 0);
  endtask

  task automatic complete(input logic [15:0] sr, input bit flow, input logic [31:0] pc);
    @(negedge clk);
    sr_in = sr; cmp_valid = 1; cmp_flow = flow; cmp_pc = pc;
    @(negedge clk);
    idle();
  endtask

  task automatic t_trace_all();
    complete(16'h8000, 0, 32'h500);
    chk(exc_req && exc_vec == 8'd9 && exc_pc == 32'h500, "R6 trace every", exc_vec, 9);
    ack();
    complete(16'h8000, 1, 32'h504);
    chk(exc_req && exc_pc == 32'h504, "R6 trace flow", exc_pc, 32'h504);
    ack();
  endtask

  task automatic t_trace_flow();
    complete(16'h4000, 0, 32'h600);
    chk(!exc_req, "R7 no flow no trace", exc_req, 0);
    complete(16'h4000, 1, 32'h700);
    chk(exc_req && exc_vec == 8'd9 && exc_pc == 32'h700, "R7 flow trace", exc_pc, 32'h700);
    ack();
  endtask

  task automatic t_trace_off();
    complete(16'h0000, 1, 32'h800);
    chk(!exc_req, "R8 T=00", exc_req, 0);
    complete(16'hC000, 1, 32'h800);
    chk(!exc_req, "R8 T=11", exc_req, 0);
  endtask

  task automatic t_priority();
    @(negedge clk);
    sr_in = 16'h8000; dec_valid = 1; dec_class = 4'd2; dec_pc = 32'h900;
    cmp_valid = 1; cmp_flow = 1; cmp_pc = 32'h9F0;
    @(negedge clk);
    idle();
    chk(exc_req && exc_vec == 8'd10 && exc_pc == 32'h900, "R9 decode over trace", exc_vec, 10);
    ack();
  endtask

  task automatic t_pending();
    bit k;
    decode(4'd1, 32'hA00, 16'h0000, k);
    @(negedge clk);
    dec_valid = 1; dec_class = 4'd3; dec_pc = 32'hB00; sr_in = 16'h8000;
    cmp_valid = 1; cmp_pc = 32'hC00;
    #0.5 chk(!exec_kill, "R10 kill while pending", exec_kill, 0);
    @(negedge clk);
    idle();
    chk(exc_req && exc_vec == 8'd4 && exc_pc == 32'hA00 && exc_sr == 16'h0000,
        "R10 hold", exc_pc, 32'hA00);
    ack();
    @(negedge clk);
    chk(!exc_req, "R10 ignored input", exc_req, 0);
  endtask

  initial begin
    #20000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!exc_req && !exec_kill, "R10 reset", exc_req, 0);
    rst_n = 1;
    t_decode_fault(4'd1, 8'd4, "R1 illegal");
    t_decode_fault(4'd2, 8'd10, "R2 line A");
    t_decode_fault(4'd3, 8'd11, "R2 line F");
    for (int c = 4; c < 16; c++) t_decode_fault(4'(c), 8'd8, "R3 privilege");
    t_illegal_super();
    t_priv_super();
    t_ordinary();
    t_trace_all();
    t_trace_flow();
    t_trace_off();
    t_priority();
    t_pending();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule